// File: doc/BRIEF.md
# Timed Transmit Queue Scheduler

This block sits at the output of a memory-side port. Upstream logic hands it packets, each carrying the earliest cycle in which it may go out. The block keeps the packets sorted by that cycle. A single wakeup timer decides when the port next tries to send. When the timer fires and the head packet is due, the head is offered downstream through a valid/ready handshake. If the downstream side refuses it, the port waits for a retry pulse before it tries again.

After every send attempt that is not refused, the timer is rearmed from two sources: the new queue head, and an external next-ready cycle supplied by a neighbouring miss queue. Outside that rearm, the timer only ever moves to an earlier cycle. An upstream sender that had a packet dropped because the queue was full receives a retry pulse one cycle after the first send that frees a slot. The block counts cycles from reset and exposes that count, so that callers can form absolute send cycles. Packet payloads are opaque.

Top module: `ttq_sched`

## Requirements
- R1: The queue holds up to DEPTH (default 8) packets and `full_o` is high when it holds DEPTH. An enqueue presented while `full_o` is high raises `ovf_o` in that cycle, and the packet is dropped and never sent.
- R2: An enqueue whose send cycle is less than or equal to the current cycle `now_o` (and the queue is not full) raises `late_o` in that cycle, and the packet is dropped.
- R3: Packets leave in ascending send-cycle order. Packets with equal send cycles leave in the order they were enqueued.
- R4: `tx_valid_o` is high only in a cycle where the wakeup fires (`wake_o` high) and the head's send cycle is at or before `now_o`. An enqueued packet that becomes the new head moves an armed timer earlier, and never moves it later.
- R5: After a send, or after a wakeup with nothing due, the timer is rearmed to the smaller of the new head's send cycle and `ext_ready_i`, but no earlier than the current cycle plus one. Two sends are therefore never in the same cycle.
- R6: An external next-ready cycle earlier than the head produces a `wake_o` pulse in that cycle, with `tx_valid_o` low when no packet is due.
- R7: When the queue is empty and `ext_ready_i` is all ones (meaning none), no wakeup is armed and `wake_o` stays low.
- R8: A refused offer (`tx_valid_o` high, `tx_ready_i` low) leaves the packet at the head and enters retry wait. In retry wait, `tx_valid_o` and `wake_o` stay low and enqueues do not arm the timer.
- R9: A `retry_i` pulse during retry wait ends the wait, and the same head packet is offered in the next cycle.
- R10: After an overflow drop, `retry_o` pulses high for one cycle, in the cycle after the first send accepted while the queue was full.
- R11: During reset, `now_o` is 0 and `tx_valid_o`, `wake_o`, `full_o` and `retry_o` are low. `now_o` increments by one every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enq_valid_i | input | 1 | Enqueue strobe |
| enq_time_i | input | TW | Earliest send cycle of the enqueued packet |
| enq_data_i | input | DW | Opaque packet payload |
| ext_ready_i | input | TW | External next-ready cycle, all ones for none |
| tx_valid_o | output | 1 | Head packet offered downstream |
| tx_data_o | output | DW | Payload of the head packet |
| tx_ready_i | input | 1 | Downstream accepts the offer |
| retry_i | input | 1 | Downstream retry pulse |
| retry_o | output | 1 | Retry pulse to upstream after an overflow |
| wake_o | output | 1 | Wakeup timer fired this cycle |
| full_o | output | 1 | Queue holds DEPTH packets |
| ovf_o | output | 1 | Enqueue dropped because the queue is full |
| late_o | output | 1 | Enqueue dropped because its send cycle is not in the future |
| now_o | output | TW | Current cycle count since reset |

## Verification
The ordering function is driven with a batch of packets whose send cycles arrive out of order, include ties, and include a packet that undercuts the current head. This separates correct sorted and stable insertion from plain arrival order, and separates a timer that moves earlier from one that stays put. The bench also packs several sends into consecutive cycles. Comparing each actual send cycle with the larger of the packet's own cycle and the previous send plus one distinguishes a correct rearm floor from an early or late rearm.

A second pattern puts an external next-ready cycle between two queued packets, which shows whether both time sources feed the rearm. A third pattern refuses an offer while a later packet comes due, which shows whether the retry wait really suppresses the timer until the retry pulse arrives.

// File: rtl/ttq_pkg.sv
package ttq_pkg;
  parameter int unsigned TTQ_DEPTH = 8;
  parameter int unsigned TTQ_TW    = 32;
  parameter int unsigned TTQ_DW    = 32;
endpackage

// File: rtl/ttq_sorted_store.sv
// Send-time ordered store: pop at head and one stable insert per cycle.
module ttq_sorted_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TW    = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic          ins_i,
  input  logic [TW-1:0] ins_time_i,
  input  logic [DW-1:0] ins_data_i,
  output logic [TW-1:0] head_time_o,
  output logic [DW-1:0] head_data_o,
  output logic [CW-1:0] count_o,
  output logic          ins_front_o,
  output logic [TW-1:0] post_head_time_o
);
  logic [TW-1:0] t_q [DEPTH];
  logic [DW-1:0] d_q [DEPTH];
  logic [TW-1:0] t_s [DEPTH];
  logic [DW-1:0] d_s [DEPTH];
  logic [TW-1:0] t_n [DEPTH];
  logic [DW-1:0] d_n [DEPTH];
  logic [CW-1:0] cnt_q, cnt_p, cnt_n, pos;

  assign cnt_p = cnt_q - CW'(pop_i);
  assign cnt_n = cnt_p + CW'(ins_i);

  for (genvar g = 0; g < DEPTH; g++) begin : g_shift
    if (g < DEPTH - 1) begin : g_mid
      assign t_s[g] = pop_i ? t_q[g+1] : t_q[g];
      assign d_s[g] = pop_i ? d_q[g+1] : d_q[g];
    end else begin : g_last
      assign t_s[g] = pop_i ? '0 : t_q[g];
      assign d_s[g] = pop_i ? '0 : d_q[g];
    end
  end

  // insert after every live entry whose time is <= the new time (stable)
  always_comb begin
    pos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < cnt_p && t_s[i] <= ins_time_i) pos = pos + CW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ins
    if (g == 0) begin : g_head
      assign t_n[g] = (ins_i && pos == '0) ? ins_time_i : t_s[g];
      assign d_n[g] = (ins_i && pos == '0) ? ins_data_i : d_s[g];
    end else begin : g_rest
      assign t_n[g] = !ins_i ? t_s[g] :
                      (CW'(g) == pos) ? ins_time_i :
                      (CW'(g) > pos)  ? t_s[g-1] : t_s[g];
      assign d_n[g] = !ins_i ? d_s[g] :
                      (CW'(g) == pos) ? ins_data_i :
                      (CW'(g) > pos)  ? d_s[g-1] : d_s[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        t_q[i] <= '0;
        d_q[i] <= '0;
      end
    end else begin
      cnt_q <= cnt_n;
      for (int i = 0; i < DEPTH; i++) begin
        t_q[i] <= t_n[i];
        d_q[i] <= d_n[i];
      end
    end
  end

  assign head_time_o      = t_q[0];
  assign head_data_o      = d_q[0];
  assign count_o          = cnt_q;
  assign ins_front_o      = (pos == '0);
  assign post_head_time_o = (cnt_n == '0) ? '1 : t_n[0];
endmodule

// File: rtl/ttq_wake_timer.sv
// Single wakeup timer. Priority: kick > kill > rearm > earlier-only schedule.
module ttq_wake_timer #(
  parameter int unsigned TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] now_i,
  input  logic          hold_i,
  input  logic          sched_i,
  input  logic [TW-1:0] sched_time_i,
  input  logic          rearm_i,
  input  logic [TW-1:0] rearm_time_i,
  input  logic          kill_i,
  input  logic          kick_i,
  output logic          due_o
);
  logic          armed_q;
  logic [TW-1:0] when_q;
  logic [TW-1:0] floor_t;

  assign floor_t = now_i + TW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      when_q  <= '0;
    end else if (kick_i) begin
      armed_q <= 1'b1;
      when_q  <= floor_t;
    end else if (kill_i) begin
      armed_q <= 1'b0;
    end else if (rearm_i) begin
      if (rearm_time_i == '1) begin
        armed_q <= 1'b0;
      end else begin
        armed_q <= 1'b1;
        when_q  <= (rearm_time_i > floor_t) ? rearm_time_i : floor_t;
      end
    end else if (sched_i && !hold_i) begin
      if (!armed_q || when_q > sched_time_i) begin
        armed_q <= 1'b1;
        when_q  <= sched_time_i;
      end
    end
  end

  assign due_o = armed_q && (when_q <= now_i);
endmodule

// File: rtl/ttq_retry_out.sv
// Upstream retry: one cycle after the first slot freed following a drop.
module ttq_retry_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drop_i,
  input  logic freed_i,
  output logic retry_o
);
  logic blocked_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blocked_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      pulse_q   <= (blocked_q || drop_i) && freed_i;
      blocked_q <= freed_i ? 1'b0 : (drop_i ? 1'b1 : blocked_q);
    end
  end

  assign retry_o = pulse_q;
endmodule

// File: rtl/ttq_sched.sv
module ttq_sched
  import ttq_pkg::*;
#(
  parameter int unsigned DEPTH = TTQ_DEPTH,
  parameter int unsigned TW    = TTQ_TW,
  parameter int unsigned DW    = TTQ_DW,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enq_valid_i,
  input  logic [TW-1:0] enq_time_i,
  input  logic [DW-1:0] enq_data_i,
  input  logic [TW-1:0] ext_ready_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_ready_i,
  input  logic          retry_i,
  output logic          retry_o,
  output logic          wake_o,
  output logic          full_o,
  output logic          ovf_o,
  output logic          late_o,
  output logic [TW-1:0] now_o
);
  logic [TW-1:0] now_q;
  logic [TW-1:0] head_t, post_t, rearm_t;
  logic [DW-1:0] head_d;
  logic [CW-1:0] count;
  logic          ins, ins_front, pop, refuse, wake_due, head_rdy, retry_wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + TW'(1);
  end

  assign full_o   = (count == CW'(DEPTH));
  assign ovf_o    = enq_valid_i && full_o;
  assign late_o   = enq_valid_i && !full_o && (enq_time_i <= now_q);
  assign ins      = enq_valid_i && !full_o && !late_o;

  assign head_rdy   = (count != '0) && (head_t <= now_q);
  assign tx_valid_o = wake_due && head_rdy;
  assign pop        = tx_valid_o && tx_ready_i;
  assign refuse     = tx_valid_o && !tx_ready_i;
  assign rearm_t    = (post_t < ext_ready_i) ? post_t : ext_ready_i;

  ttq_sorted_store #(.DEPTH(DEPTH), .TW(TW), .DW(DW)) u_store (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .pop_i           (pop),
    .ins_i           (ins),
    .ins_time_i      (enq_time_i),
    .ins_data_i      (enq_data_i),
    .head_time_o     (head_t),
    .head_data_o     (head_d),
    .count_o         (count),
    .ins_front_o     (ins_front),
    .post_head_time_o(post_t)
  );

  ttq_wake_timer #(.TW(TW)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .now_i       (now_q),
    .hold_i      (retry_wait_q),
    .sched_i     (ins && ins_front),
    .sched_time_i(enq_time_i),
    .rearm_i     (wake_due && !refuse),
    .rearm_time_i(rearm_t),
    .kill_i      (refuse),
    .kick_i      (retry_i && retry_wait_q),
    .due_o       (wake_due)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      retry_wait_q <= 1'b0;
    else if (retry_i && retry_wait_q) retry_wait_q <= 1'b0;
    else if (refuse)                  retry_wait_q <= 1'b1;
  end

  ttq_retry_out u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .drop_i (ovf_o),
    .freed_i(pop && full_o),
    .retry_o(retry_o)
  );

  assign tx_data_o = head_d;
  assign wake_o    = wake_due;
  assign now_o     = now_q;
endmodule

// File: rtl/ttq_sched_chk.sv
module ttq_sched_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enq_valid_i,
  input logic tx_valid_o,
  input logic tx_ready_i,
  input logic retry_i,
  input logic retry_o,
  input logic wake_o,
  input logic full_o,
  input logic ovf_o,
  input logic late_o,
  input logic retry_wait
);
  p_ovf_full_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (full_o && enq_valid_i));

  p_late_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_o |-> (enq_valid_i && !full_o));

  p_send_on_wake_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> wake_o);

  p_quiet_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_wait |-> (!tx_valid_o && !wake_o));

  p_refuse_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> !tx_valid_o);

  p_retry_resend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_i && retry_wait) |=> tx_valid_o);

  p_retry_out_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> $past(tx_valid_o && tx_ready_i && full_o));
endmodule

bind ttq_sched ttq_sched_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enq_valid_i(enq_valid_i),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .retry_i    (retry_i),
  .retry_o    (retry_o),
  .wake_o     (wake_o),
  .full_o     (full_o),
  .ovf_o      (ovf_o),
  .late_o     (late_o),
  .retry_wait (retry_wait_q)
);

// File: tb/ttq_sched_tb.sv
module ttq_sched_tb;
  localparam int TW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enq_valid;
  logic [TW-1:0] enq_time;
  logic [DW-1:0] enq_data;
  logic [TW-1:0] ext_ready;
  logic          tx_valid, tx_ready, retry_in, retry_out, wake, full, ovf, late;
  logic [DW-1:0] tx_data;
  logic [TW-1:0] now;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ttq_sched u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .enq_valid_i(enq_valid), .enq_time_i(enq_time), .enq_data_i(enq_data),
    .ext_ready_i(ext_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .retry_i(retry_in), .retry_o(retry_out), .wake_o(wake),
    .full_o(full), .ovf_o(ovf), .late_o(late), .now_o(now)
  );

  // stimulus table: send-cycle offsets and payloads
  localparam logic [7:0]    VOFS [8] = '{8'd5, 8'd2, 8'd9, 8'd2, 8'd0, 8'd7, 8'd5, 8'd12};
  localparam logic [DW-1:0] VDAT [8] = '{32'h11, 32'h22, 32'h33, 32'h44,
                                        32'h55, 32'h66, 32'h77, 32'h88};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic push(input longint t, input logic [DW-1:0] d);
    enq_valid = 1'b1;
    enq_time  = TW'(t);
    enq_data  = d;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    report();
  end

  initial begin
    longint base, c;
    longint exp_t [8];
    int     ord [8];
    int     k, stray, wk;

    rst_n = 1'b0; enq_valid = 1'b0; enq_time = '0; enq_data = '0;
    ext_ready = '1; tx_ready = 1'b1; retry_in = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(now == 0 && !tx_valid && !wake && !full && !retry_out, "R11 reset", now, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(now == 1, "R11 count", now, 1);

    // R2 late enqueue dropped
    enq_valid = 1'b1; enq_time = now; enq_data = 32'hDEAD;
    #1 chk(late == 1'b1, "R2 late flag", late, 1);
    @(negedge clk);
    enq_valid = 1'b0;
    stray = 0;
    for (int i = 0; i < 6; i++) begin
      if (tx_valid || wake) stray++;
      @(negedge clk);
    end
    chk(stray == 0, "R2 late not sent", stray, 0);

    // table: unsorted times with ties, filled to overflow
    base = now;
    for (int i = 0; i < 8; i++) push(base + 20 + VOFS[i], VDAT[i]);
    chk(full == 1'b1, "R1 full", full, 1);
    enq_valid = 1'b1; enq_time = TW'(base + 40); enq_data = 32'hEE;
    #1 chk(ovf == 1'b1, "R1 overflow flag", ovf, 1);
    @(negedge clk);
    enq_valid = 1'b0;

    // expected order: stable sort by offset
    for (int i = 0; i < 8; i++) ord[i] = i;
    for (int i = 1; i < 8; i++) begin
      for (int j = i; j > 0; j--) begin
        if (VOFS[ord[j-1]] > VOFS[ord[j]]) begin
          int tmp;
          tmp = ord[j]; ord[j] = ord[j-1]; ord[j-1] = tmp;
        end
      end
    end
    for (int i = 0; i < 8; i++) begin
      exp_t[i] = base + 20 + VOFS[ord[i]];
      if (i > 0 && exp_t[i] <= exp_t[i-1]) exp_t[i] = exp_t[i-1] + 1;
    end

    k = 0; stray = 0;
    while (now < base + 45) begin
      chk(retry_out == (now == base + 21), "R10 retry out", retry_out, now == base + 21);
      if (wake && !tx_valid) stray++;
      if (tx_valid) begin
        if (k < 8) begin
          chk(tx_data == VDAT[ord[k]], "R3 order", tx_data, VDAT[ord[k]]);
          chk(now == exp_t[k], "R5 send cycle", now - base, exp_t[k] - base);
        end else begin
          chk(0, "R1 dropped packet sent", tx_data, 0);
        end
        k++;
      end
      @(negedge clk);
    end
    chk(k == 8, "R1 send count", k, 8);
    chk(stray == 0, "R7 no idle wake", stray, 0);

    // external next-ready between two packets
    base = now;
    ext_ready = TW'(base + 6);
    push(base + 3, 32'hA1);
    push(base + 10, 32'hB2);
    wk = 0;
    while (now <= base + 13) begin
      c = now - base;
      if (c == 3) chk(tx_valid && tx_data == 32'hA1, "R4 first due", tx_data, 32'hA1);
      if (c == 4 || c == 5) chk(!wake, "R6 no early wake", wake, 0);
      if (c == 6) begin
        chk(wake && !tx_valid, "R6 external wake", {wake, tx_valid}, 2);
        ext_ready = '1;
      end
      if (c >= 7 && c <= 9 && wake) wk++;
      if (c == 10) chk(tx_valid && tx_data == 32'hB2, "R5 head after ext", tx_data, 32'hB2);
      if (c >= 11) chk(!wake, "R7 empty idle", wake, 0);
      @(negedge clk);
    end
    chk(wk == 0, "R5 rearm to head", wk, 0);

    // refusal and retry
    tx_ready = 1'b0;
    base = now;
    push(base + 3, 32'h5A);
    while (now < base + 3) @(negedge clk);
    chk(tx_valid && tx_data == 32'h5A, "R8 offered", tx_data, 32'h5A);
    @(negedge clk);
    push(base + 6, 32'h6B);
    stray = 0;
    while (now < base + 10) begin
      if (tx_valid || wake) stray++;
      @(negedge clk);
    end
    chk(stray == 0, "R8 quiet in wait", stray, 0);
    retry_in = 1'b1;
    @(negedge clk);
    retry_in = 1'b0;
    chk(tx_valid && tx_data == 32'h5A, "R9 resend after retry", tx_data, 32'h5A);
    tx_ready = 1'b1;
    @(negedge clk);
    chk(tx_valid && tx_data == 32'h6B && now == base + 12, "R5 floor next cycle", now - base, 12);
    @(negedge clk);
    chk(!tx_valid && !full, "R3 drained", tx_valid, 0);

    report();
  end
endmodule